// File: doc/BRIEF.md
# Programmable Sync and Data-Enable Strobe Generator

This block produces the three raster strobes of a video frame: vertical sync, horizontal sync and data enable. It also produces the column and row coordinates that a downstream pattern source needs. Every duration is a run-time value counted in pixel clocks, or in pulses, and is supplied on input buses. No standard video mode is built in. The vertical strobe is timed purely in clock cycles. The horizontal and data-enable trains are each launched by their own offset counted from the vertical rising edge. Each train stops after a programmed number of pulses.

The frame repeats for as long as the enable input is held high. The configuration buses are captured only at frame boundaries, so software may rewrite them at any time without tearing the frame in progress. The strobes are plain level outputs with no back-pressure. A pattern source follows them cycle for cycle.

Top module: `video_strobe_gen`

## Requirements
- R1: At the first clock edge that samples `enable` high, a new run starts. `vs` stays low for `cfg_vs_delay` cycles and then rises. A delay of 0 makes `vs` high in the very first cycle of the run.
- R2: Once running, `vs` is high for `cfg_vs_high` cycles and then low for `cfg_vs_low` cycles. This repeats with no idle cycle between frames. Both values must be at least 1.
- R3: `hs` first rises `cfg_hs_delay` cycles after the cycle in which `vs` rises. A delay of 0 makes `hs` rise in that same cycle. Each pulse is high for `cfg_hs_high` cycles and is followed by `cfg_hs_low` low cycles; both must be at least 1.
- R4: Exactly `cfg_hs_count` pulses of `hs` are produced per frame. After the last pulse, `hs` stays low until the next rise of `vs`. A count of 0 gives no `hs` pulse at all.
- R5: `de` follows the same rules as R3 and R4, using its own offset, high time, low time and pulse count (`cfg_de_*`).
- R6: A rise of `vs` restarts both trains from their offsets, even when the previous frame's train has not finished.
- R7: `pix_x` counts the consecutive `de`-high cycles before the current cycle. It reads 0 in the first active pixel of a line. It shows the line length in the first cycle after `de` falls, and 0 after that.
- R8: `pix_y` is cleared in the cycle in which `vs` rises. It advances by one in the cycle after the first `de`-low cycle of each line, so it reads the 0-based line index during every active line.
- R9: The configuration inputs are captured when a run starts and again at each later rise of `vs`. A change made in the middle of a frame has no effect until the next rise of `vs`.
- R10: When `enable` is sampled low, `vs`, `hs`, `de`, `pix_x` and `pix_y` are all 0 from the next cycle on. The next enable starts a fresh run as in R1.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the generator; low stops it and clears all outputs |
| cfg_vs_delay | input | 24 | Cycles from run start to the first rise of vs |
| cfg_vs_high | input | 24 | Cycles vs stays high |
| cfg_vs_low | input | 24 | Cycles vs stays low between frames |
| cfg_hs_delay | input | 24 | Cycles from the rise of vs to the first hs pulse |
| cfg_hs_high | input | 16 | Cycles hs is high per pulse |
| cfg_hs_low | input | 16 | Cycles hs is low between pulses |
| cfg_hs_count | input | 16 | Number of hs pulses per frame |
| cfg_de_delay | input | 24 | Cycles from the rise of vs to the first de pulse |
| cfg_de_high | input | 16 | Active pixels per line |
| cfg_de_low | input | 16 | Blanking cycles between active lines |
| cfg_de_count | input | 16 | Active lines per frame |
| vs | output | 1 | Vertical sync strobe |
| hs | output | 1 | Horizontal sync strobe |
| de | output | 1 | Data-enable strobe |
| pix_x | output | 16 | Column of the current pixel |
| pix_y | output | 16 | Row of the current line |

## Verification
Every output is compared against an independent model on every clock. A wrong phase or an off-by-one counter therefore shows up in the first cycle where a strobe edge moves: at a `vs` edge, at the first `hs` or `de` edge after it, or at the cycle where a train should end. A frame-capture fault only shows up at the next frame boundary. To catch it, the configuration is changed in the middle of a frame and the following frame is observed. Coordinate faults show up on the first active pixel of a line, or on the first line after the rise of `vs`.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  // Phase of a counted strobe: idle, waiting out an offset, pulse high,
  // pulse gap, or finished for this frame.
  typedef enum logic [2:0] {
    PH_OFF,
    PH_WAIT,
    PH_ON,
    PH_GAP,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/vtg_frame.sv
module vtg_frame
  import vtg_pkg::*;
#(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [TW-1:0] dly,
  input  logic [TW-1:0] hi,
  input  logic [TW-1:0] lo,
  output logic          vs,
  output logic          launch,
  output logic          frame_load
);
  localparam logic [TW-1:0] ONE = TW'(1);

  phase_e        st;
  logic [TW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  // Capture configuration at run start and at every frame wrap.
  assign frame_load = enable && ((st == PH_OFF) || (st == PH_GAP && cnt_zero));
  // The next cycle is the first high cycle of vs.
  assign launch = enable && ((st == PH_OFF && dly == '0) ||
                             (st == PH_WAIT && cnt_zero) ||
                             (st == PH_GAP && cnt_zero));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PH_OFF;
      cnt <= '0;
    end else if (!enable) begin
      st  <= PH_OFF;
      cnt <= '0;
    end else begin
      case (st)
        PH_OFF: begin
          if (dly == '0) begin
            st  <= PH_ON;
            cnt <= hi - ONE;
          end else begin
            st  <= PH_WAIT;
            cnt <= dly - ONE;
          end
        end
        PH_WAIT: begin
          if (cnt_zero) begin
            st  <= PH_ON;
            cnt <= hi - ONE;
          end else cnt <= cnt - ONE;
        end
        PH_ON: begin
          if (cnt_zero) begin
            st  <= PH_GAP;
            cnt <= lo - ONE;
          end else cnt <= cnt - ONE;
        end
        PH_GAP: begin
          if (cnt_zero) begin
            st  <= PH_ON;
            cnt <= hi - ONE;
          end else cnt <= cnt - ONE;
        end
        default: st <= PH_OFF;
      endcase
    end
  end

  assign vs = (st == PH_ON);

  // R10: a low enable clears vs on the next cycle
  p_vs_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !vs);
  // R2: every rise of vs is announced by a launch
  p_vs_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs) |-> $past(launch));
endmodule

// File: rtl/vtg_train.sv
module vtg_train
  import vtg_pkg::*;
#(
  parameter int TW = 24,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          launch,
  input  logic [TW-1:0] dly,
  input  logic [PW-1:0] hi,
  input  logic [PW-1:0] lo,
  input  logic [PW-1:0] count,
  output logic          pulse
);
  localparam logic [TW-1:0] ONE_T = TW'(1);
  localparam logic [PW-1:0] ONE_P = PW'(1);

  phase_e        st;
  logic [TW-1:0] cnt;
  logic [PW-1:0] rem;
  logic [TW-1:0] hi_t, lo_t;
  logic          cnt_zero;

  assign hi_t     = TW'(hi);
  assign lo_t     = TW'(lo);
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PH_OFF;
      cnt <= '0;
      rem <= '0;
    end else if (!enable) begin
      st  <= PH_OFF;
      cnt <= '0;
      rem <= '0;
    end else if (launch) begin
      rem <= count - ONE_P;
      if (count == '0) begin
        st <= PH_DONE;
      end else if (dly == '0) begin
        st  <= PH_ON;
        cnt <= hi_t - ONE_T;
      end else begin
        st  <= PH_WAIT;
        cnt <= dly - ONE_T;
      end
    end else begin
      case (st)
        PH_WAIT: begin
          if (cnt_zero) begin
            st  <= PH_ON;
            cnt <= hi_t - ONE_T;
          end else cnt <= cnt - ONE_T;
        end
        PH_ON: begin
          if (cnt_zero) begin
            if (rem == '0) st <= PH_DONE;
            else begin
              st  <= PH_GAP;
              cnt <= lo_t - ONE_T;
            end
          end else cnt <= cnt - ONE_T;
        end
        PH_GAP: begin
          if (cnt_zero) begin
            st  <= PH_ON;
            cnt <= hi_t - ONE_T;
            rem <= rem - ONE_P;
          end else cnt <= cnt - ONE_T;
        end
        default: ;
      endcase
    end
  end

  assign pulse = (st == PH_ON);

  // R10: a low enable silences the train
  p_train_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pulse);
  // R4: a finished train stays low until relaunched
  p_train_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !launch && st == PH_DONE) |=> !pulse);
  // R3: zero offset with a nonzero count pulses at once
  p_train_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && launch && dly == '0 && count != '0) |=> pulse);
endmodule

// File: rtl/vtg_coord.sv
module vtg_coord #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          launch,
  input  logic          de,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_x <= '0;
      pix_y <= '0;
    end else if (!enable) begin
      pix_x <= '0;
      pix_y <= '0;
    end else begin
      pix_x <= de ? pix_x + ONE : '0;
      if (launch) pix_y <= '0;
      else if (!de && pix_x != '0) pix_y <= pix_y + ONE;
    end
  end

  // R7: column returns to zero one cycle after the line's first blank cycle
  p_x_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(de) |=> (pix_x == '0));
  // R8: row is cleared at the rise of vs
  p_y_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && launch) |=> (pix_y == '0));
endmodule

// File: rtl/video_strobe_gen.sv
module video_strobe_gen #(
  parameter int TIME_W  = 24,
  parameter int PULSE_W = 16,
  parameter int COORD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [TIME_W-1:0]  cfg_vs_delay,
  input  logic [TIME_W-1:0]  cfg_vs_high,
  input  logic [TIME_W-1:0]  cfg_vs_low,
  input  logic [TIME_W-1:0]  cfg_hs_delay,
  input  logic [PULSE_W-1:0] cfg_hs_high,
  input  logic [PULSE_W-1:0] cfg_hs_low,
  input  logic [PULSE_W-1:0] cfg_hs_count,
  input  logic [TIME_W-1:0]  cfg_de_delay,
  input  logic [PULSE_W-1:0] cfg_de_high,
  input  logic [PULSE_W-1:0] cfg_de_low,
  input  logic [PULSE_W-1:0] cfg_de_count,
  output logic               vs,
  output logic               hs,
  output logic               de,
  output logic [COORD_W-1:0] pix_x,
  output logic [COORD_W-1:0] pix_y
);
  localparam int CFG_W = 5 * TIME_W + 6 * PULSE_W;

  logic [CFG_W-1:0] cfg_in, cfg_hold, cfg_use;
  logic             frame_load, launch;

  logic [TIME_W-1:0]  u_vs_dly, u_vs_hi, u_vs_lo, u_hs_dly, u_de_dly;
  logic [PULSE_W-1:0] u_hs_hi, u_hs_lo, u_hs_cnt, u_de_hi, u_de_lo, u_de_cnt;

  assign cfg_in = {cfg_vs_delay, cfg_vs_high, cfg_vs_low,
                   cfg_hs_delay, cfg_hs_high, cfg_hs_low, cfg_hs_count,
                   cfg_de_delay, cfg_de_high, cfg_de_low, cfg_de_count};

  // Frame-boundary capture: the live value is used in the capture cycle itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_hold <= '0;
    else if (frame_load) cfg_hold <= cfg_in;
  end

  assign cfg_use = frame_load ? cfg_in : cfg_hold;

  assign {u_vs_dly, u_vs_hi, u_vs_lo,
          u_hs_dly, u_hs_hi, u_hs_lo, u_hs_cnt,
          u_de_dly, u_de_hi, u_de_lo, u_de_cnt} = cfg_use;

  vtg_frame #(.TW(TIME_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .dly(u_vs_dly), .hi(u_vs_hi), .lo(u_vs_lo),
    .vs(vs), .launch(launch), .frame_load(frame_load)
  );

  vtg_train #(.TW(TIME_W), .PW(PULSE_W)) u_hs_train (
    .clk(clk), .rst_n(rst_n), .enable(enable), .launch(launch),
    .dly(u_hs_dly), .hi(u_hs_hi), .lo(u_hs_lo), .count(u_hs_cnt),
    .pulse(hs)
  );

  vtg_train #(.TW(TIME_W), .PW(PULSE_W)) u_de_train (
    .clk(clk), .rst_n(rst_n), .enable(enable), .launch(launch),
    .dly(u_de_dly), .hi(u_de_hi), .lo(u_de_lo), .count(u_de_cnt),
    .pulse(de)
  );

  vtg_coord #(.CW(COORD_W)) u_coord (
    .clk(clk), .rst_n(rst_n), .enable(enable), .launch(launch),
    .de(de), .pix_x(pix_x), .pix_y(pix_y)
  );

  // R9: captured configuration holds between frame boundaries
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> $stable(cfg_hold));
endmodule

// File: tb/test_video_strobe_gen.sv
module test_video_strobe_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [23:0] vs_delay, vs_high, vs_low, hs_delay, de_delay;
  logic [15:0] hs_high, hs_low, hs_count, de_high, de_low, de_count;
  logic vs, hs, de;
  logic [15:0] pix_x, pix_y;

  always #(CLK_PERIOD / 2) clk = ~clk;

  video_strobe_gen i_video_strobe_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_vs_delay(vs_delay), .cfg_vs_high(vs_high), .cfg_vs_low(vs_low),
    .cfg_hs_delay(hs_delay), .cfg_hs_high(hs_high), .cfg_hs_low(hs_low),
    .cfg_hs_count(hs_count),
    .cfg_de_delay(de_delay), .cfg_de_high(de_high), .cfg_de_low(de_low),
    .cfg_de_count(de_count),
    .vs(vs), .hs(hs), .de(de), .pix_x(pix_x), .pix_y(pix_y)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 0;
  string phase = "R11";
  int    hs_rises = 0;
  logic  hs_prev = 1'b0;

  // Reference model state
  int m_run = 0, m_t = 0, m_fs = 0;
  int c_vdly, c_vhi, c_vlo, c_hdly, c_hhi, c_hlo, c_hcnt, c_ddly, c_dhi, c_dlo, c_dcnt;
  int m_vs = 0, m_hs = 0, m_de = 0, m_x = 0, m_y = 0;

  function automatic int train_level(int r, int d, int h, int l, int n);
    int q;
    if (n == 0 || r < d) return 0;
    q = r - d;
    if (q / (h + l) >= n) return 0;
    return ((q % (h + l)) < h) ? 1 : 0;
  endfunction

  task automatic capture_cfg();
    c_vdly = vs_delay; c_vhi = vs_high; c_vlo = vs_low;
    c_hdly = hs_delay; c_hhi = hs_high; c_hlo = hs_low; c_hcnt = hs_count;
    c_ddly = de_delay; c_dhi = de_high; c_dlo = de_low; c_dcnt = de_count;
  endtask

  task automatic check(input int actual, input int expected, input string tag, input string what);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s %s actual=%0d expected=%0d at cycle %0d",
               phase, tag, what, actual, expected, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Model advances at each active edge from the inputs seen there.
  always @(posedge clk) begin
    int px, pd, lnch, r;
    cyc++;
    if (!rst_n || !enable) begin
      m_run = 0; m_vs = 0; m_hs = 0; m_de = 0; m_x = 0; m_y = 0;
    end else begin
      px = m_x; pd = m_de;
      if (m_run == 0) begin
        m_run = 1; m_t = 0; capture_cfg(); m_fs = c_vdly;
      end else begin
        m_t++;
        if (m_t == m_fs + c_vhi + c_vlo) begin
          m_fs = m_t; capture_cfg();
        end
      end
      lnch = (m_t == m_fs) ? 1 : 0;
      if (m_t < m_fs) begin
        m_vs = 0; m_hs = 0; m_de = 0;
      end else begin
        r = m_t - m_fs;
        m_vs = (r < c_vhi) ? 1 : 0;
        m_hs = train_level(r, c_hdly, c_hhi, c_hlo, c_hcnt);
        m_de = train_level(r, c_ddly, c_dhi, c_dlo, c_dcnt);
      end
      m_x = pd ? px + 1 : 0;
      if (lnch) m_y = 0;
      else if (pd == 0 && px != 0) m_y = m_y + 1;
    end
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(vs), m_vs, (m_run != 0 && m_t < m_fs) ? "R1" : "R2", "vs");
      check(int'(hs), m_hs, "R3", "hs");
      check(int'(de), m_de, "R5", "de");
      check(int'(pix_x), m_x, "R7", "pix_x");
      check(int'(pix_y), m_y, "R8", "pix_y");
      if (hs && !hs_prev) hs_rises++;
      hs_prev = hs;
    end
  end

  task automatic set_cfg(input int vd, input int vh, input int vl,
                         input int hd, input int hh, input int hl, input int hn,
                         input int dd, input int dh, input int dl, input int dn);
    vs_delay = 24'(vd); vs_high = 24'(vh); vs_low = 24'(vl);
    hs_delay = 24'(hd); hs_high = 16'(hh); hs_low = 16'(hl); hs_count = 16'(hn);
    de_delay = 24'(dd); de_high = 16'(dh); de_low = 16'(dl); de_count = 16'(dn);
  endtask

  initial begin
    set_cfg(5, 3, 45, 0, 2, 4, 8, 7, 5, 3, 4);
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R11: outputs idle in reset
    check(int'(vs), 0, "R11", "vs in reset");
    check(int'(hs), 0, "R11", "hs in reset");
    check(int'(de), 0, "R11", "de in reset");
    check(int'(pix_x), 0, "R11", "pix_x in reset");
    check(int'(pix_y), 0, "R11", "pix_y in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 and R2: delayed start, then steady frames
    phase = "R1";
    enable = 1'b1;
    repeat (160) @(negedge clk);

    // R4: zero hs count, single de line, zero vs delay
    phase = "R10";
    enable = 1'b0;
    repeat (4) @(negedge clk);
    set_cfg(0, 4, 30, 2, 2, 2, 0, 0, 6, 2, 1);
    phase = "R4";
    hs_rises = 0;
    enable = 1'b1;
    repeat (110) @(negedge clk);
    check(hs_rises, 0, "R4", "hs pulses with zero count");

    // R6: trains longer than a frame get restarted by vs
    phase = "R10";
    enable = 1'b0;
    repeat (3) @(negedge clk);
    set_cfg(1, 2, 20, 1, 3, 3, 50, 0, 4, 2, 50);
    phase = "R6";
    enable = 1'b1;
    repeat (100) @(negedge clk);

    // R9: change configuration mid-frame
    phase = "R9";
    repeat (7) @(negedge clk);
    set_cfg(9, 3, 25, 0, 1, 2, 6, 3, 3, 1, 5);
    repeat (120) @(negedge clk);

    // R10: drop enable mid-frame, then restart
    phase = "R10";
    enable = 1'b0;
    repeat (6) @(negedge clk);
    check(int'(vs | hs | de), 0, "R10", "strobes while disabled");
    check(int'(pix_x) + int'(pix_y), 0, "R10", "coordinates while disabled");
    enable = 1'b1;
    repeat (100) @(negedge clk);

    finish_run();
  end
endmodule